// File: doc/BRIEF.md
# Store-Triggered Thread Wake Monitor

This block keeps the park-and-wake bookkeeping for two hardware threads that share a core. A thread arms the block with a monitor command that carries a base address. From then on, a store that lands inside a fixed-size window starting at that base is remembered as a pending event for that thread. The thread then issues a wait command. If an event is already pending, the wait completes at once. Otherwise the thread parks until a store hits its window or one of its asynchronous event lines fires. The block then emits a one-cycle wake pulse together with a cause code.

While exactly one thread is parked, the block tells the core to give the shared resources to the other thread. While both threads are parked, it raises a low-power request. The block does not decode instructions, deliver interrupts or control power.

Commands arrive on a valid/ready port. `cmd_ready` drops while the addressed thread (`cmd_thread`) is parked, because a parked thread cannot issue. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. The sender must hold its fields stable until that edge. `cmd_ready` depends only on `cmd_thread` and the parked state, never on `cmd_valid`. The store bus and the event lines only carry observations, so they have no back-pressure.

Top module: `wake_monitor`

## Requirements
- R1: An accepted monitor command (`cmd_op`=0) with zero operands sets the thread's base to `cmd_addr`, clears its pending flag and arms it. If a store hits the same thread's window in the same cycle, the command wins and the flag stays cleared.
- R2: An accepted command whose extension or hint operand is nonzero raises `cmd_err` for one cycle after the accepting edge and leaves the thread's state and base unchanged.
- R3: A store hits a thread's window when `st_addr - base` is below `SPAN_BYTES` (default 64). Stores outside the window, and stores while the thread is unarmed, have no effect.
- R4: A hitting store on an armed thread sets its pending flag. A later wait from that thread completes at once: a wake pulse with cause 1 (store), the thread returns to idle and it never parks.
- R5: A wait on an armed thread with no pending event parks it (`thr_waiting` bit set). A hitting store then wakes it with cause 1, and the thread returns to idle.
- R6: Event line bit i (0 interrupt, 1 NMI, 2 SMI, 3 debug, 4 machine check, 5 bus init, 6 INIT, 7 reset) wakes a parked thread with cause i+2. When several bits are set, the highest index wins, and events take priority over a store in the same cycle. Bits 0 to 6 have no effect on a thread that is not parked.
- R7: Event bit 7 clears the thread's armed, pending and parked state in any state. If the thread was parked, it wakes it with cause 9.
- R8: While exactly one thread is parked, `recombine` is high and `recombine_to` names the running thread.
- R9: While both threads are parked, `lp_req` is high and `recombine` is low.
- R10: `cmd_ready` is low while the thread named by `cmd_thread` is parked. A wait on an idle (unarmed) thread completes at once with cause 0.
- R11: Each wake is a one-cycle pulse on `wake_t0`/`wake_t1`, due in the cycle after the accepting or sampling edge. The pulse coincides with a valid cause on `cause_t0`/`cause_t1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready; low while the addressed thread is parked |
| cmd_thread | input | 1 | Issuing thread |
| cmd_op | input | 1 | 0 monitor, 1 wait |
| cmd_addr | input | ADDR_W | Window base for monitor |
| cmd_ext | input | OPND_W | Extension operand, must be zero |
| cmd_hint | input | OPND_W | Hint operand, must be zero |
| st_valid | input | 1 | Store observed |
| st_addr | input | ADDR_W | Store byte address |
| evt_t0 | input | 8 | Event lines for thread 0 |
| evt_t1 | input | 8 | Event lines for thread 1 |
| wake_t0 | output | 1 | Wake pulse, thread 0 |
| wake_t1 | output | 1 | Wake pulse, thread 1 |
| cause_t0 | output | 4 | Wake cause, thread 0 |
| cause_t1 | output | 4 | Wake cause, thread 1 |
| cmd_err | output | 1 | Rejected command pulse |
| thr_waiting | output | 2 | Parked flag per thread |
| recombine | output | 1 | Exactly one thread parked |
| recombine_to | output | 1 | Thread that receives the resources |
| lp_req | output | 1 | Both threads parked |

## Verification
Wake pulses, causes, `cmd_err` and `thr_waiting` are registered, so each is due exactly one edge after the edge that sampled its stimulus. `recombine` and `lp_req` follow `thr_waiting` in the same cycle, and `cmd_ready` follows `cmd_thread` combinationally. The bench drives on falling edges and samples on the next falling edge, after exactly one rising edge. A driver pushes each expected (thread, cause) wake into a queue when it issues the stimulus. A monitor pops the queue on every observed pulse. An unexpected pulse, a wrong cause, or a wake still queued at the end each count as a failure.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int CAUSE_W = 4;
  localparam int N_EVT = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } thr_st_e;

  localparam logic OP_MONITOR = 1'b0;
  localparam logic OP_WAIT    = 1'b1;

  localparam logic [CAUSE_W-1:0] CAUSE_UNARMED  = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE    = 4'd1;
  localparam int                 CAUSE_EVT_BASE = 2;
endpackage

// File: rtl/wm_range_cmp.sv
module wm_range_cmp #(
  parameter int          ADDR_W     = 32,
  parameter logic [15:0] SPAN_BYTES = 16'd64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SPAN_EXT = ADDR_W'(SPAN_BYTES);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - base;
    hit    = offset < SPAN_EXT;
  end
endmodule

// File: rtl/wm_cause_enc.sv
module wm_cause_enc
  import wm_pkg::*;
#(
  parameter int NE = N_EVT
) (
  input  logic [NE-1:0]      evt,
  output logic               any,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    any   = |evt;
    cause = CAUSE_UNARMED;
    for (int i = 0; i < NE; i++) begin
      if (evt[i]) cause = CAUSE_W'(CAUSE_EVT_BASE + i);
    end
  end
endmodule

// File: rtl/wm_thread_fsm.sv
module wm_thread_fsm
  import wm_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          OPND_W     = 32,
  parameter logic [15:0] SPAN_BYTES = 16'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_fire,
  input  logic               cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [OPND_W-1:0]  cmd_ext,
  input  logic [OPND_W-1:0]  cmd_hint,
  input  logic               st_valid,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [N_EVT-1:0]   evt,
  output logic               waiting,
  output logic               wake,
  output logic [CAUSE_W-1:0] cause,
  output logic               err
);
  thr_st_e              state_q, state_d;
  logic [ADDR_W-1:0]    base_q, base_d;
  logic                 pend_q, pend_d;
  logic                 wake_q, wake_d;
  logic [CAUSE_W-1:0]   cause_q, cause_d;
  logic                 err_q, err_d;

  logic                 in_win, st_hit, opnd_ok, cmd_take, ev_any, rst_evt;
  logic [CAUSE_W-1:0]   ev_cause;

  wm_range_cmp #(.ADDR_W(ADDR_W), .SPAN_BYTES(SPAN_BYTES)) u_win (
    .addr(st_addr), .base(base_q), .hit(in_win)
  );

  wm_cause_enc #(.NE(N_EVT)) u_enc (
    .evt(evt), .any(ev_any), .cause(ev_cause)
  );

  always_comb begin
    st_hit   = st_valid && in_win;
    opnd_ok  = (cmd_ext == '0) && (cmd_hint == '0);
    cmd_take = cmd_fire && opnd_ok;
    rst_evt  = evt[N_EVT-1];

    state_d = state_q;
    base_d  = base_q;
    pend_d  = pend_q;
    wake_d  = 1'b0;
    cause_d = cause_q;
    err_d   = cmd_fire && !opnd_ok && (state_q != ST_WAIT);

    if (rst_evt) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      if (state_q == ST_WAIT) begin
        wake_d  = 1'b1;
        cause_d = ev_cause;
      end
    end else if (state_q == ST_WAIT) begin
      if (ev_any) begin
        wake_d  = 1'b1;
        cause_d = ev_cause;
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end else if (st_hit) begin
        wake_d  = 1'b1;
        cause_d = CAUSE_STORE;
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end
    end else if (cmd_take) begin
      if (cmd_op == OP_MONITOR) begin
        state_d = ST_ARMED;
        base_d  = cmd_addr;
        pend_d  = 1'b0;
      end else if (state_q == ST_IDLE) begin
        wake_d  = 1'b1;
        cause_d = CAUSE_UNARMED;
      end else if (pend_q || st_hit) begin
        wake_d  = 1'b1;
        cause_d = CAUSE_STORE;
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end else begin
        state_d = ST_WAIT;
      end
    end else if ((state_q == ST_ARMED) && st_hit) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      pend_q  <= 1'b0;
      wake_q  <= 1'b0;
      cause_q <= CAUSE_UNARMED;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      pend_q  <= pend_d;
      wake_q  <= wake_d;
      cause_q <= cause_d;
      err_q   <= err_d;
    end
  end

  assign waiting = (state_q == ST_WAIT);
  assign wake    = wake_q;
  assign cause   = cause_q;
  assign err     = err_q;

  p_arm_clears_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ARMED) |-> !pend_q);

  p_err_keeps_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(base_q));

  p_pend_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (state_q == ST_ARMED));

  p_event_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && (|evt)) |=> (wake_q && (state_q == ST_IDLE)));

  p_wake_leaves_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state_q != ST_WAIT));
endmodule

// File: rtl/wm_power_arb.sv
module wm_power_arb (
  input  logic [1:0] waiting,
  output logic       recombine,
  output logic       recombine_to,
  output logic       lp_req
);
  always_comb begin
    lp_req       = &waiting;
    recombine    = waiting[0] ^ waiting[1];
    recombine_to = waiting[0];
  end
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor
  import wm_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          OPND_W     = 32,
  parameter logic [15:0] SPAN_BYTES = 16'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_thread,
  input  logic               cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [OPND_W-1:0]  cmd_ext,
  input  logic [OPND_W-1:0]  cmd_hint,
  input  logic               st_valid,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [N_EVT-1:0]   evt_t0,
  input  logic [N_EVT-1:0]   evt_t1,
  output logic               wake_t0,
  output logic               wake_t1,
  output logic [CAUSE_W-1:0] cause_t0,
  output logic [CAUSE_W-1:0] cause_t1,
  output logic               cmd_err,
  output logic [1:0]         thr_waiting,
  output logic               recombine,
  output logic               recombine_to,
  output logic               lp_req
);
  localparam int N_THR = 2;

  logic [N_EVT-1:0]   evt_a   [N_THR];
  logic [N_THR-1:0]   wake_a;
  logic [CAUSE_W-1:0] cause_a [N_THR];
  logic [N_THR-1:0]   err_a;

  assign evt_a[0]  = evt_t0;
  assign evt_a[1]  = evt_t1;
  assign cmd_ready = !thr_waiting[cmd_thread];

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic fire;
    assign fire = cmd_valid && cmd_ready && (cmd_thread == 1'(t));

    wm_thread_fsm #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .SPAN_BYTES(SPAN_BYTES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_fire (fire),
      .cmd_op   (cmd_op),
      .cmd_addr (cmd_addr),
      .cmd_ext  (cmd_ext),
      .cmd_hint (cmd_hint),
      .st_valid (st_valid),
      .st_addr  (st_addr),
      .evt      (evt_a[t]),
      .waiting  (thr_waiting[t]),
      .wake     (wake_a[t]),
      .cause    (cause_a[t]),
      .err      (err_a[t])
    );
  end

  wm_power_arb u_pwr (
    .waiting      (thr_waiting),
    .recombine    (recombine),
    .recombine_to (recombine_to),
    .lp_req       (lp_req)
  );

  assign wake_t0  = wake_a[0];
  assign wake_t1  = wake_a[1];
  assign cause_t0 = cause_a[0];
  assign cause_t1 = cause_a[1];
  assign cmd_err  = |err_a;

  p_no_accept_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> !thr_waiting[cmd_thread]);

  p_recombine_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recombine |-> !thr_waiting[recombine_to]);

  p_lp_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> !recombine);
endmodule

// File: tb/wake_monitor_tb_top.sv
module wake_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_thread = 1'b0;
  logic        cmd_op = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_ext = '0;
  logic [31:0] cmd_hint = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [7:0]  evt_t0 = '0;
  logic [7:0]  evt_t1 = '0;
  logic        wake_t0, wake_t1;
  logic [3:0]  cause_t0, cause_t1;
  logic        cmd_err;
  logic [1:0]  thr_waiting;
  logic        recombine, recombine_to, lp_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_thread(cmd_thread), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_ext(cmd_ext), .cmd_hint(cmd_hint), .st_valid(st_valid), .st_addr(st_addr),
    .evt_t0(evt_t0), .evt_t1(evt_t1), .wake_t0(wake_t0), .wake_t1(wake_t1),
    .cause_t0(cause_t0), .cause_t1(cause_t1), .cmd_err(cmd_err),
    .thr_waiting(thr_waiting), .recombine(recombine), .recombine_to(recombine_to),
    .lp_req(lp_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_wake(input logic thr, input logic [3:0] cause);
    exp_q.push_back({thr, cause});
  endtask

  // scoreboard monitor: every pulse must match the oldest expected wake
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < 2; t++) begin
        logic w;
        logic [3:0] c;
        w = (t == 0) ? wake_t0 : wake_t1;
        c = (t == 0) ? cause_t0 : cause_t1;
        if (w) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected wake actual=t%0d/c%0d expected=none", t, c);
          end else begin
            logic [4:0] e;
            e = exp_q.pop_front();
            if (e !== {1'(t), c}) begin
              errors++;
              $display("FAIL R11 wake actual=t%0d/c%0d expected=t%0d/c%0d",
                       t, c, e[4], e[3:0]);
            end
          end
        end
      end
    end
  end

  task automatic do_cmd(input logic thr, input logic op, input logic [31:0] addr,
                        input logic [31:0] ext = 0, input logic [31:0] hint = 0);
    cmd_valid = 1'b1; cmd_thread = thr; cmd_op = op; cmd_addr = addr;
    cmd_ext = ext; cmd_hint = hint;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_ext = '0; cmd_hint = '0;
  endtask

  task automatic do_store(input logic [31:0] addr);
    st_valid = 1'b1; st_addr = addr;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_evt(input logic thr, input logic [7:0] bits);
    if (thr) evt_t1 = bits; else evt_t0 = bits;
    @(negedge clk);
    evt_t0 = '0; evt_t1 = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset recombine", 32'(recombine), 0);
    chk("R9 reset lp_req", 32'(lp_req), 0);
    chk("R5 reset waiting", 32'(thr_waiting), 0);
    chk("R11 reset wake", 32'({wake_t1, wake_t0}), 0);
    chk("R10 reset ready", 32'(cmd_ready), 1);

    // R1 arm, R5 park and wake on last byte of window (R3)
    do_cmd(0, 0, 32'h1000);
    do_cmd(0, 1, 32'h0);
    chk("R5 parked", 32'(thr_waiting), 32'b01);
    chk("R8 recombine one", 32'(recombine), 1);
    chk("R8 recombine_to", 32'(recombine_to), 1);
    cmd_thread = 1'b0; #1;
    chk("R10 ready low parked", 32'(cmd_ready), 0);
    cmd_thread = 1'b1; #1;
    chk("R10 ready other thread", 32'(cmd_ready), 1);
    expect_wake(0, 4'd1);
    do_store(32'h103F);
    chk("R5 resumed", 32'(thr_waiting), 0);
    @(negedge clk);
    chk("R11 single pulse", 32'(wake_t0), 0);

    // R3 outside addresses do not wake; R9 both parked
    do_cmd(0, 0, 32'h1000);
    do_store(32'h1040);
    do_store(32'h0FFF);
    do_cmd(0, 1, 32'h0);
    chk("R3 outside store left no pending", 32'(thr_waiting), 32'b01);
    do_cmd(1, 0, 32'h2000);
    do_cmd(1, 1, 32'h0);
    chk("R9 lp_req", 32'(lp_req), 1);
    chk("R9 recombine low", 32'(recombine), 0);
    do_store(32'h1040);
    chk("R3 outside store no wake", 32'(thr_waiting), 32'b11);

    // R6 priority: NMI over interrupt -> cause 3
    expect_wake(1, 4'd3);
    do_evt(1, 8'b0000_0011);
    chk("R6 thread1 resumed", 32'(thr_waiting), 32'b01);
    chk("R8 recombine_to t1", 32'(recombine_to), 1);
    // R7 reset event on parked thread -> cause 9
    expect_wake(0, 4'd9);
    do_evt(0, 8'b1000_0100);
    chk("R7 parked cleared", 32'(thr_waiting), 0);

    // R4 pending store then wait falls through
    do_cmd(0, 0, 32'h3000);
    do_store(32'h3010);
    expect_wake(0, 4'd1);
    do_cmd(0, 1, 32'h0);
    chk("R4 no park", 32'(thr_waiting), 0);

    // R1 re-arm clears pending
    do_cmd(1, 0, 32'h3000);
    do_store(32'h3000);
    do_cmd(1, 0, 32'h3000);
    do_cmd(1, 1, 32'h0);
    chk("R1 rearm cleared pending", 32'(thr_waiting), 32'b10);
    expect_wake(1, 4'd1);
    do_store(32'h3000);

    // R2 rejected monitor leaves thread idle; R10 idle wait -> cause 0
    do_cmd(0, 0, 32'h5000, 32'h1, 32'h0);
    chk("R2 err pulse", 32'(cmd_err), 1);
    @(negedge clk);
    chk("R2 err one cycle", 32'(cmd_err), 0);
    expect_wake(0, 4'd0);
    do_cmd(0, 1, 32'h0);
    chk("R10 idle wait no park", 32'(thr_waiting), 0);

    // R2 rejected re-arm keeps old base
    do_cmd(0, 0, 32'h6000);
    do_cmd(0, 0, 32'h7000, 32'h0, 32'h2);
    chk("R2 err on hint", 32'(cmd_err), 1);
    do_store(32'h6000);
    expect_wake(0, 4'd1);
    do_cmd(0, 1, 32'h0);
    chk("R2 base kept", 32'(thr_waiting), 0);

    // R6 events ignored when not parked
    do_cmd(1, 0, 32'h8000);
    do_evt(1, 8'b0001_0000);
    do_cmd(1, 1, 32'h0);
    chk("R6 event ignored while armed", 32'(thr_waiting), 32'b10);
    expect_wake(1, 4'd6);
    do_evt(1, 8'b0001_0000);

    // R7 reset event on armed thread disarms it
    do_cmd(0, 0, 32'h9000);
    do_evt(0, 8'b1000_0000);
    do_store(32'h9000);
    expect_wake(0, 4'd0);
    do_cmd(0, 1, 32'h0);
    chk("R7 disarmed", 32'(thr_waiting), 0);

    repeat (3) @(negedge clk);
    chk("R11 all wakes seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule